// File: doc/BRIEF.md
# Signed Magnitude Comparator Using Lookahead Subtraction

This block compares two two's complement operands, X and Y, without any clock or state. It forms the difference X minus Y by adding X to the bitwise inverse of Y with a carry-in of one. Each bit has a generate term and a propagate term, and each carry is a flat two-level sum of products of those terms. No carry ripples from one bit to the next.

The sum and the carries give four condition codes: carry, negative, zero and overflow. The five relation outputs come only from those codes: equal, less, less-or-equal, greater-or-equal and greater. Because the overflow code corrects the sign of the difference, every relation is a signed comparison. The codes are also brought out, so a neighbouring block can use them as ALU-style flags. The operand width defaults to 4 bits.

Top module: `signed_cmp_top`

## Requirements
- R1: `flag_n` equals the most significant bit of (X - Y) taken modulo 2^WIDTH.
- R2: `flag_z` is 1 exactly when (X - Y) modulo 2^WIDTH is zero.
- R3: `flag_v` is 1 exactly when the operand signs differ and the sign of the difference differs from the sign of X, so that the true signed difference falls outside the WIDTH-bit range (for example -8 minus 7 and 7 minus -8 at WIDTH 4).
- R4: `flag_c` is the carry out of X + ~Y + 1: it is 1 when X is at least Y read as unsigned numbers, and 0 on a borrow.
- R5: `x_eq_y` is 1 exactly when X equals Y.
- R6: `x_lt_y` is 1 exactly when X is less than Y as signed numbers.
- R7: `x_le_y` is 1 exactly when X is less than or equal to Y as signed numbers.
- R8: `x_ge_y` is 1 exactly when X is greater than or equal to Y as signed numbers.
- R9: `x_gt_y` is 1 exactly when X is greater than Y as signed numbers.
- R10: Exactly one of `x_lt_y`, `x_eq_y` and `x_gt_y` is 1 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | Operand X, two's complement |
| y_in | input | WIDTH | Operand Y, two's complement |
| x_eq_y | output | 1 | X equals Y |
| x_lt_y | output | 1 | X less than Y, signed |
| x_le_y | output | 1 | X less than or equal to Y, signed |
| x_ge_y | output | 1 | X greater than or equal to Y, signed |
| x_gt_y | output | 1 | X greater than Y, signed |
| flag_c | output | 1 | Carry out of the subtraction (1 = no borrow) |
| flag_n | output | 1 | Sign bit of the difference |
| flag_z | output | 1 | Difference is zero |
| flag_v | output | 1 | Signed overflow in the subtraction |

## Verification
The bound checker tests every settled input combination against arithmetic written in its own terms. It covers these behaviours:
- each relation against a signed compare of the ports;
- the carry code against an unsigned compare;
- the overflow code against the operand and result signs;
- the mutual exclusion of less, equal and greater.

Only the bench's scenarios can show that the whole operand space is handled. The bench sweeps every pair at the default width. It also drives directed overflow corners, such as the most negative operand against the most positive one, where the raw sign of the difference gives the wrong answer and only the overflow correction keeps the relations correct.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
        logic v;
    } cond_codes_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic le;
        logic ge;
        logic gt;
    } relations_t;

    // Signed relations taken from the condition codes only
    function automatic relations_t relate_from_codes(cond_codes_t cc);
        relations_t r;
        r.eq = cc.z;
        r.lt = cc.n ^ cc.v;
        r.le = r.lt | r.eq;
        r.ge = ~r.lt;
        r.gt = ~r.le;
        return r;
    endfunction

endpackage

// File: rtl/cmp_gp.sv
module cmp_gp #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_op,
    input  logic [WIDTH-1:0] b_op,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    // Subtrahend enters inverted; carry-in of one completes the negation
    logic [WIDTH-1:0] b_inv;
    assign b_inv = ~b_op;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen[i]  = a_op[i] & b_inv[i];
        assign prop[i] = a_op[i] ^ b_inv[i];
    end
endmodule

// File: rtl/cmp_lookahead.sv
module cmp_lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic             carry_in,
    output logic [WIDTH:0]   carry
);
    assign carry[0] = carry_in;

    // Each carry is an independent sum of products: no rippling
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        logic c_next;
        always_comb begin : la_terms
            logic acc;
            logic term;
            acc = carry_in;
            for (int k = 0; k <= i; k++) acc = acc & prop[k];
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prop[k];
                acc = acc | term;
            end
            c_next = acc;
        end
        assign carry[i+1] = c_next;
    end
endmodule

// File: rtl/cmp_flags.sv
module cmp_flags
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH:0]   carry,
    output logic [WIDTH-1:0] diff,
    output cond_codes_t      codes
);
    localparam int MSB = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign diff[i] = prop[i] ^ carry[i];
    end

    always_comb begin
        codes.c = carry[WIDTH];
        codes.n = diff[MSB];
        codes.z = ~|diff;
        codes.v = carry[WIDTH] ^ carry[MSB];
    end
endmodule

// File: rtl/signed_cmp_top.sv
module signed_cmp_top
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    output logic             x_eq_y,
    output logic             x_lt_y,
    output logic             x_le_y,
    output logic             x_ge_y,
    output logic             x_gt_y,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v
);
    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH:0]   carry_w;
    logic [WIDTH-1:0] diff_w;
    cond_codes_t      codes_w;
    relations_t       rel_w;

    cmp_gp #(.WIDTH(WIDTH)) u_gp (
        .a_op (x_in),
        .b_op (y_in),
        .gen  (gen_w),
        .prop (prop_w)
    );

    cmp_lookahead #(.WIDTH(WIDTH)) u_la (
        .gen      (gen_w),
        .prop     (prop_w),
        .carry_in (1'b1),
        .carry    (carry_w)
    );

    cmp_flags #(.WIDTH(WIDTH)) u_flags (
        .prop  (prop_w),
        .carry (carry_w),
        .diff  (diff_w),
        .codes (codes_w)
    );

    assign rel_w  = relate_from_codes(codes_w);

    assign x_eq_y = rel_w.eq;
    assign x_lt_y = rel_w.lt;
    assign x_le_y = rel_w.le;
    assign x_ge_y = rel_w.ge;
    assign x_gt_y = rel_w.gt;
    assign flag_c = codes_w.c;
    assign flag_n = codes_w.n;
    assign flag_z = codes_w.z;
    assign flag_v = codes_w.v;
endmodule

// File: rtl/signed_cmp_checker.sv
module signed_cmp_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] x_in,
    input logic [WIDTH-1:0] y_in,
    input logic             x_eq_y,
    input logic             x_lt_y,
    input logic             x_le_y,
    input logic             x_ge_y,
    input logic             x_gt_y,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v
);
    logic [WIDTH-1:0] ref_diff;
    assign ref_diff = x_in - y_in;

    always_comb begin
        AST_NEG_SIGN:    assert (flag_n == ref_diff[WIDTH-1]); // R1
        AST_ZERO_DIFF:   assert (flag_z == (ref_diff == '0)); // R2
        AST_OVERFLOW:    assert (flag_v == ((x_in[WIDTH-1] != y_in[WIDTH-1]) && (ref_diff[WIDTH-1] != x_in[WIDTH-1]))); // R3
        AST_NO_BORROW:   assert (flag_c == (x_in >= y_in)); // R4
        AST_EQUAL:       assert (x_eq_y == (x_in == y_in)); // R5
        AST_LESS:        assert (x_lt_y == ($signed(x_in) < $signed(y_in))); // R6
        AST_LESS_EQ:     assert (x_le_y == ($signed(x_in) <= $signed(y_in))); // R7
        AST_GREATER_EQ:  assert (x_ge_y == ($signed(x_in) >= $signed(y_in))); // R8
        AST_GREATER:     assert (x_gt_y == ($signed(x_in) > $signed(y_in))); // R9
        AST_ONE_RELATION: assert ($onehot({x_lt_y, x_eq_y, x_gt_y})); // R10
    end
endmodule

bind signed_cmp_top signed_cmp_checker #(.WIDTH(WIDTH)) u_chk (
    .x_in   (x_in),
    .y_in   (y_in),
    .x_eq_y (x_eq_y),
    .x_lt_y (x_lt_y),
    .x_le_y (x_le_y),
    .x_ge_y (x_ge_y),
    .x_gt_y (x_gt_y),
    .flag_c (flag_c),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_v (flag_v)
);

// File: tb/tb_signed_cmp_top.sv
module tb_signed_cmp_top;
    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x_in, y_in;
    logic eq, lt, le, ge, gt, fc, fn, fz, fv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    signed_cmp_top #(.WIDTH(W)) dut (
        .x_in (x_in), .y_in (y_in),
        .x_eq_y (eq), .x_lt_y (lt), .x_le_y (le), .x_ge_y (ge), .x_gt_y (gt),
        .flag_c (fc), .flag_n (fn), .flag_z (fz), .flag_v (fv)
    );

    function automatic int sval(logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%0d y=%0d actual=%0b expected=%0b",
                     req, sval(x_in), sval(y_in), act, exp);
        end
    endtask

    task automatic apply_and_check(logic [W-1:0] xv, logic [W-1:0] yv);
        int sx, sy, tru;
        logic [W-1:0] d;
        @(posedge clk);
        x_in = xv;
        y_in = yv;
        @(negedge clk);
        sx  = sval(xv);
        sy  = sval(yv);
        tru = sx - sy;
        d   = xv - yv;
        check_bit("R1", fn, d[W-1]);
        check_bit("R2", fz, d == '0);
        check_bit("R3", fv, (tru > (1 << (W-1)) - 1) || (tru < -(1 << (W-1))));
        check_bit("R4", fc, int'(xv) >= int'(yv));
        check_bit("R5", eq, sx == sy);
        check_bit("R6", lt, sx < sy);
        check_bit("R7", le, sx <= sy);
        check_bit("R8", ge, sx >= sy);
        check_bit("R9", gt, sx > sy);
        check_bit("R10", logic'(int'(lt) + int'(eq) + int'(gt) == 1), 1'b1);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unused_seed;
        x_in = '0;
        y_in = '0;
        unused_seed = $urandom(32'd2015);
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Idle operands: equal zeros
        apply_and_check(4'b0000, 4'b0000);
        // Overflow corners (R3): -8 - 7 and 7 - (-8)
        apply_and_check(4'b1000, 4'b0111);
        apply_and_check(4'b0111, 4'b1000);
        apply_and_check(4'b1000, 4'b0001);
        apply_and_check(4'b1111, 4'b1111);
        // Exhaustive sweep
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                apply_and_check(W'(a), W'(b));
        // Random mix
        for (int n = 0; n < 200; n++)
            apply_and_check(W'($urandom), W'($urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule